// File: doc/BRIEF.md
# Multi-Bank DRAM Command Timing Guard

This block sits between a memory controller's command front end and the DRAM pins. Each clock the front end offers at most one command with a bank number and, for an activation, a row. The guard decides in that same cycle whether the command may go out. It raises a grant flag if the command is legal and a stall flag if it is not. A granted command updates the guard's model of the banks on the clock edge that ends the cycle. A stalled command leaves the model unchanged, so the front end can simply offer it again.

The guard keeps an open or idle flag and an open row for every bank. All spacing rules are parameters counted in clock cycles. They cover the per-bank rules for activate, column access, precharge and re-activate, and the rule between activations of different banks. On top of these it enforces column-burst spacing, write recovery before precharge, and write-to-read turnaround. Mode-register writes and auto-refresh are allowed only when every bank is idle. Each one then blocks all later commands for its own recovery window.

Top module: `bank_guard`

## Requirements
- R1: Command codes on cmdCode are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all, 6 auto-refresh, 7 mode-register write. With cmdValid high and a nonzero code, exactly one of cmdGrant (legal) or cmdStall (illegal) is high in that same cycle. With cmdValid low or code 0, both flags are low. After reset all banks are idle and all timers have expired.
- R2: An activate is legal only to an idle bank. When granted, it marks the bank open and records cmdRow as that bank's row on the same edge.
- R3: A read or write is illegal to an idle bank. It is also illegal until at least T_RCD cycles after that bank's activate.
- R4: A precharge to an open bank needs at least T_RAS cycles since its activate, and then closes the bank. A precharge to an idle bank is legal and changes nothing.
- R5: An activate to a bank needs at least T_RC cycles since that bank's previous activate and at least T_RP cycles since it was closed.
- R6: An activate to any bank needs at least T_RRD cycles since the most recent activate to any bank.
- R7: Closing a bank, by a precharge of that bank or a precharge-all, needs at least BURST_CYC + T_WR cycles since the last write to that bank.
- R8: A read to any bank needs at least BURST_CYC + T_WTR cycles since the most recent write, so a write burst is never cut short by a read.
- R9: Successive column commands (read or write, any banks) are at least BURST_CYC cycles apart.
- R10: A precharge-all is legal only when every open bank meets R4 and R7. It closes all banks.
- R11: A mode-register write or an auto-refresh is legal only when every bank is idle and at least T_RP cycles have passed since each bank was last closed.
- R12: After a mode-register write, every command is stalled for T_MRD cycles. After an auto-refresh, every command is stalled for T_RFC cycles.
- R13: A stalled command changes no bank's open flag or row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is offered this cycle |
| cmdCode | input | 3 | Command code (see R1) |
| cmdBank | input | BANK_W | Target bank |
| cmdRow | input | ROW_W | Row for an activate |
| cmdGrant | output | 1 | Offered command is legal and issues at the coming edge |
| cmdStall | output | 1 | Offered command is illegal and is dropped |
| bankOpen | output | NUM_BANKS | Per-bank open flag |
| bankRowFlat | output | NUM_BANKS*ROW_W | Open row of each bank, bank i at bits i*ROW_W upward |

## Verification
Every spacing rule is swept over gaps from one cycle up to a little past its limit. Each sweep starts from a fresh reset, so the first legal gap shows that exact limit and is not hidden by a longer rule. The activate-to-column sweep covers every bank with both reads and writes, and the column-to-column sweep covers all four read/write orders. These separate the burst spacing from the longer write-to-read turnaround. Other patterns use two open banks: a write to one followed by a read to the other, and an activate to one bank followed by an activate to another. They show which rules are global and which are per bank. The bench also offers illegal commands (re-activating an open bank, a mode write with a bank open) and then reads back the open flags and rows, so it can tell a clean stall from a partial state update.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6,
    CMD_MRS  = 3'd7
  } cmd_e;

  // Issue strobes from the control to the datapath; at most one is high.
  typedef struct packed {
    logic actStb;
    logic rdStb;
    logic wrStb;
    logic preStb;
    logic preAllStb;
    logic refStb;
    logic mrsStb;
  } strobe_t;

endpackage

// File: rtl/bank_guard_timer.sv
// Down-counter that loads on a strobe and reports expiry when it reaches zero.
module bank_guard_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)           cnt <= '0;
    else if (load)       cnt <= loadVal;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/bank_guard_datapath.sv
// Bank state: open flags, open rows and all spacing timers.
module bank_guard_datapath
  import bank_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 7,
  parameter int T_RC      = 10,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_WTR     = 2,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 12,
  parameter int BURST_CYC = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [BANK_W-1:0]          bankSel,
  input  logic [ROW_W-1:0]           rowIn,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS-1:0]       rcdDone,
  output logic [NUM_BANKS-1:0]       rasDone,
  output logic [NUM_BANKS-1:0]       rcDone,
  output logic [NUM_BANKS-1:0]       rpDone,
  output logic [NUM_BANKS-1:0]       wrDone,
  output logic                       rrdDone,
  output logic                       wtrDone,
  output logic                       burstDone,
  output logic                       mrdDone,
  output logic                       rfcDone,
  output logic [NUM_BANKS*ROW_W-1:0] bankRowFlat
);

  localparam int CNT_W = $clog2(T_RCD + T_RAS + T_RC + T_RP + T_RRD + T_WR
                                + T_WTR + T_MRD + T_RFC + 2 * BURST_CYC + 2);
  localparam logic [CNT_W-1:0] LD_RCD   = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_RAS   = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] LD_RC    = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] LD_RP    = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_RRD   = CNT_W'(T_RRD - 1);
  localparam logic [CNT_W-1:0] LD_WREC  = CNT_W'(BURST_CYC + T_WR - 1);
  localparam logic [CNT_W-1:0] LD_WTR   = CNT_W'(BURST_CYC + T_WTR - 1);
  localparam logic [CNT_W-1:0] LD_BURST = CNT_W'(BURST_CYC - 1);
  localparam logic [CNT_W-1:0] LD_MRD   = CNT_W'(T_MRD - 1);
  localparam logic [CNT_W-1:0] LD_RFC   = CNT_W'(T_RFC - 1);

  logic [ROW_W-1:0] rowArr [NUM_BANKS];

  for (genvar i = 0; i < NUM_BANKS; i++) begin : gBank
    logic             hit;
    logic             actHere;
    logic             wrHere;
    logic             closeHere;
    logic             openQ;
    logic [ROW_W-1:0] rowQ;

    assign hit       = (bankSel == BANK_W'(i));
    assign actHere   = stb.actStb && hit;
    assign wrHere    = stb.wrStb && hit;
    assign closeHere = openQ && ((stb.preStb && hit) || stb.preAllStb);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ <= 1'b0;
        rowQ  <= '0;
      end else if (actHere) begin
        openQ <= 1'b1;
        rowQ  <= rowIn;
      end else if (closeHere) begin
        openQ <= 1'b0;
      end
    end

    assign bankOpen[i]                    = openQ;
    assign rowArr[i]                      = rowQ;
    assign bankRowFlat[i*ROW_W +: ROW_W]  = rowQ;

    bank_guard_timer #(.W(CNT_W)) uRcd (.clk(clk), .rstN(rstN), .load(actHere),
      .loadVal(LD_RCD), .done(rcdDone[i]));
    bank_guard_timer #(.W(CNT_W)) uRas (.clk(clk), .rstN(rstN), .load(actHere),
      .loadVal(LD_RAS), .done(rasDone[i]));
    bank_guard_timer #(.W(CNT_W)) uRc (.clk(clk), .rstN(rstN), .load(actHere),
      .loadVal(LD_RC), .done(rcDone[i]));
    bank_guard_timer #(.W(CNT_W)) uRp (.clk(clk), .rstN(rstN), .load(closeHere),
      .loadVal(LD_RP), .done(rpDone[i]));
    bank_guard_timer #(.W(CNT_W)) uWr (.clk(clk), .rstN(rstN), .load(wrHere),
      .loadVal(LD_WREC), .done(wrDone[i]));
  end

  bank_guard_timer #(.W(CNT_W)) uRrd (.clk(clk), .rstN(rstN), .load(stb.actStb),
    .loadVal(LD_RRD), .done(rrdDone));
  bank_guard_timer #(.W(CNT_W)) uWtr (.clk(clk), .rstN(rstN), .load(stb.wrStb),
    .loadVal(LD_WTR), .done(wtrDone));
  bank_guard_timer #(.W(CNT_W)) uBurst (.clk(clk), .rstN(rstN),
    .load(stb.rdStb || stb.wrStb), .loadVal(LD_BURST), .done(burstDone));
  bank_guard_timer #(.W(CNT_W)) uMrd (.clk(clk), .rstN(rstN), .load(stb.mrsStb),
    .loadVal(LD_MRD), .done(mrdDone));
  bank_guard_timer #(.W(CNT_W)) uRfc (.clk(clk), .rstN(rstN), .load(stb.refStb),
    .loadVal(LD_RFC), .done(rfcDone));

  // R2: an issued activate opens its bank with the offered row
  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.actStb |=> bankOpen[$past(bankSel)] && (rowArr[$past(bankSel)] == $past(rowIn)));

  // R10: an issued precharge-all leaves every bank idle
  assert_prea_closes_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.preAllStb |=> (bankOpen == '0));

  // R9: a column strobe restarts the burst window
  assert_burst_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStb || stb.wrStb) && (BURST_CYC > 1) |=> !burstDone);

endmodule

// File: rtl/bank_guard_ctrl.sv
// Legality decision and issue strobes.
module bank_guard_ctrl
  import bank_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdCode,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [NUM_BANKS-1:0] rcdDone,
  input  logic [NUM_BANKS-1:0] rasDone,
  input  logic [NUM_BANKS-1:0] rcDone,
  input  logic [NUM_BANKS-1:0] rpDone,
  input  logic [NUM_BANKS-1:0] wrDone,
  input  logic                 rrdDone,
  input  logic                 wtrDone,
  input  logic                 burstDone,
  input  logic                 mrdDone,
  input  logic                 rfcDone,
  output strobe_t              stb,
  output logic                 cmdGrant,
  output logic                 cmdStall
);

  cmd_e cmd;
  logic active;
  logic legal;
  logic quiet;
  logic allIdle;
  logic selOpen;
  logic [NUM_BANKS-1:0] closeOk;

  assign cmd     = cmd_e'(cmdCode);
  assign active  = cmdValid && (cmd != CMD_NOP);
  assign quiet   = mrdDone && rfcDone;
  assign allIdle = (bankOpen == '0) && (&rpDone);
  assign selOpen = bankOpen[cmdBank];
  assign closeOk = ~bankOpen | (rasDone & wrDone);

  always_comb begin
    unique case (cmd)
      CMD_ACT:  legal = !selOpen && rcDone[cmdBank] && rpDone[cmdBank] && rrdDone;
      CMD_RD:   legal = selOpen && rcdDone[cmdBank] && burstDone && wtrDone;
      CMD_WR:   legal = selOpen && rcdDone[cmdBank] && burstDone;
      CMD_PRE:  legal = closeOk[cmdBank];
      CMD_PREA: legal = &closeOk;
      CMD_REF:  legal = allIdle;
      CMD_MRS:  legal = allIdle;
      default:  legal = 1'b0;
    endcase
  end

  assign cmdGrant = active && legal && quiet;
  assign cmdStall = active && !(legal && quiet);

  always_comb begin
    stb           = '0;
    stb.actStb    = cmdGrant && (cmd == CMD_ACT);
    stb.rdStb     = cmdGrant && (cmd == CMD_RD);
    stb.wrStb     = cmdGrant && (cmd == CMD_WR);
    stb.preStb    = cmdGrant && (cmd == CMD_PRE);
    stb.preAllStb = cmdGrant && (cmd == CMD_PREA);
    stb.refStb    = cmdGrant && (cmd == CMD_REF);
    stb.mrsStb    = cmdGrant && (cmd == CMD_MRS);
  end

  // R1: at most one strobe per cycle
  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R3: column command to an idle bank is never granted
  assert_col_needs_open_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && ((cmd == CMD_RD) || (cmd == CMD_WR)) && !bankOpen[cmdBank] |-> cmdStall);

  // R11: mode write with any bank open is stalled
  assert_mrs_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmd == CMD_MRS) && (bankOpen != '0) |-> cmdStall);

  // R13: a stalled command leaves the open flags as they were
  assert_stall_freezes_R13: assert property (@(posedge clk) disable iff (!rstN)
    cmdStall |=> (bankOpen == $past(bankOpen)));

endmodule

// File: rtl/bank_guard.sv
module bank_guard
  import bank_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 7,
  parameter int T_RC      = 10,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_WTR     = 2,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 12,
  parameter int BURST_CYC = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  input  logic [2:0]                 cmdCode,
  input  logic [BANK_W-1:0]          cmdBank,
  input  logic [ROW_W-1:0]           cmdRow,
  output logic                       cmdGrant,
  output logic                       cmdStall,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] bankRowFlat
);

  strobe_t              stb;
  logic [NUM_BANKS-1:0] rcdDone, rasDone, rcDone, rpDone, wrDone;
  logic                 rrdDone, wtrDone, burstDone, mrdDone, rfcDone;

  bank_guard_ctrl #(.NUM_BANKS(NUM_BANKS)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdBank(cmdBank), .bankOpen(bankOpen), .rcdDone(rcdDone),
    .rasDone(rasDone), .rcDone(rcDone), .rpDone(rpDone), .wrDone(wrDone),
    .rrdDone(rrdDone), .wtrDone(wtrDone), .burstDone(burstDone),
    .mrdDone(mrdDone), .rfcDone(rfcDone), .stb(stb),
    .cmdGrant(cmdGrant), .cmdStall(cmdStall)
  );

  bank_guard_datapath #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
    .T_RC(T_RC), .T_RP(T_RP), .T_RRD(T_RRD), .T_WR(T_WR), .T_WTR(T_WTR),
    .T_MRD(T_MRD), .T_RFC(T_RFC), .BURST_CYC(BURST_CYC)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .bankSel(cmdBank), .rowIn(cmdRow),
    .bankOpen(bankOpen), .rcdDone(rcdDone), .rasDone(rasDone),
    .rcDone(rcDone), .rpDone(rpDone), .wrDone(wrDone), .rrdDone(rrdDone),
    .wtrDone(wtrDone), .burstDone(burstDone), .mrdDone(mrdDone),
    .rfcDone(rfcDone), .bankRowFlat(bankRowFlat)
  );

endmodule

// File: tb/bank_guard_test.sv
`timescale 1ns/1ps
module bank_guard_test;

  localparam int T_RCD = 3, T_RAS = 7, T_RC = 10, T_RP = 3, T_RRD = 2;
  localparam int T_WR = 2, T_WTR = 2, T_MRD = 2, T_RFC = 12, BURST = 2;
  localparam int ROW_W = 12;
  localparam logic [2:0] NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4,
                         PREA = 5, REF = 6, MRS = 7;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cmdValid = 1'b0;
  logic [2:0]       cmdCode = '0;
  logic [1:0]       cmdBank = '0;
  logic [ROW_W-1:0] cmdRow = '0;
  logic             cmdGrant, cmdStall;
  logic [3:0]       bankOpen;
  logic [4*ROW_W-1:0] bankRowFlat;

  int  nChecks = 0;
  int  nFail = 0;
  bit  finished = 0;
  logic g;

  bank_guard uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdGrant(cmdGrant),
    .cmdStall(cmdStall), .bankOpen(bankOpen), .bankRowFlat(bankRowFlat)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    cmdValid = 1'b0; cmdCode = NOP; rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Offer a command in the next cycle; grant is sampled before the edge that issues it.
  task automatic step(input logic [2:0] code, input int bank, input int row,
                      output logic grant);
    @(negedge clk);
    cmdValid = (code != NOP);
    cmdCode  = code;
    cmdBank  = bank[1:0];
    cmdRow   = row[ROW_W-1:0];
    #1;
    grant = cmdGrant;
  endtask

  task automatic idle(input int n);
    logic dummy;
    for (int i = 0; i < n; i++) step(NOP, 0, 0, dummy);
  endtask

  function automatic int rowOf(input int b);
    return int'(bankRowFlat[b*ROW_W +: ROW_W]);
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: reset state and quiet flags
    #1;
    chk("R1 reset bankOpen", bankOpen, 0);
    chk("R1 idle grant", cmdGrant, 0);
    chk("R1 idle stall", cmdStall, 0);
    step(NOP, 0, 0, g);
    chk("R1 nop grant", cmdGrant, 0);
    step(RD, 0, 0, g);
    chk("R1 illegal stall flag", cmdStall, 1);
    chk("R1 illegal grant flag", g, 0);

    // R2: activate records row
    doReset();
    step(ACT, 2, 12'h5A5, g);
    chk("R2 act grant", g, 1);
    idle(1);
    chk("R2 bank open", bankOpen, 4'b0100);
    chk("R2 row", rowOf(2), 12'h5A5);
    step(ACT, 2, 12'h111, g);
    chk("R2 act to open bank", g, 0);

    // R3: activate to column sweep, every bank, read and write
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 2; c++)
        for (int gap = 1; gap <= T_RCD + 2; gap++) begin
          doReset();
          step(ACT, b, b + 1, g);
          idle(gap - 1);
          step(c ? WR : RD, b, 0, g);
          chk($sformatf("R3 bank%0d wr%0d gap%0d", b, c, gap), g, gap >= T_RCD);
        end
    doReset();
    step(WR, 1, 0, g);
    chk("R3 write to idle bank", g, 0);

    // R4: activate to precharge sweep
    for (int gap = 1; gap <= T_RAS + 2; gap++) begin
      doReset();
      step(ACT, 0, 7, g);
      idle(gap - 1);
      step(PRE, 0, 0, g);
      chk($sformatf("R4 pre gap%0d", gap), g, gap >= T_RAS);
      idle(1);
      chk($sformatf("R4 closed gap%0d", gap), bankOpen[0], gap < T_RAS);
    end
    doReset();
    step(PRE, 2, 0, g);
    chk("R4 pre idle bank legal", g, 1);
    idle(1);
    chk("R4 pre idle no effect", bankOpen, 0);
    step(ACT, 2, 3, g);
    chk("R4 act right after idle pre", g, 1);

    // R5: same-bank re-activate after row cycle
    for (int gap = T_RAS + 1; gap <= T_RC + 2; gap++) begin
      doReset();
      step(ACT, 1, 1, g);
      idle(T_RAS - 1);
      step(PRE, 1, 0, g);
      idle(gap - T_RAS - 1);
      step(ACT, 1, 2, g);
      chk($sformatf("R5 rc gap%0d", gap), g, (gap >= T_RC) && (gap - T_RAS >= T_RP));
    end
    for (int p = 1; p <= T_RP + 2; p++) begin
      doReset();
      step(ACT, 3, 1, g);
      idle(T_RC + 1);
      step(PRE, 3, 0, g);
      idle(p - 1);
      step(ACT, 3, 2, g);
      chk($sformatf("R5 rp gap%0d", p), g, p >= T_RP);
    end

    // R6 and R13: activate to another bank
    for (int b = 1; b < 4; b++)
      for (int gap = 1; gap <= T_RRD + 2; gap++) begin
        doReset();
        step(ACT, 0, 1, g);
        idle(gap - 1);
        step(ACT, b, 9, g);
        chk($sformatf("R6 bank%0d gap%0d", b, gap), g, gap >= T_RRD);
        idle(1);
        chk($sformatf("R13 open after rrd bank%0d gap%0d", b, gap), bankOpen[b], gap >= T_RRD);
      end

    // R7: write recovery before precharge
    for (int w = 1; w <= BURST + T_WR + 2; w++) begin
      doReset();
      step(ACT, 0, 1, g);
      idle(T_RAS);
      step(WR, 0, 0, g);
      idle(w - 1);
      step(PRE, 0, 0, g);
      chk($sformatf("R7 pre after wr gap%0d", w), g, w >= BURST + T_WR);
    end

    // R8: write to one bank, read another
    for (int w = 1; w <= BURST + T_WTR + 2; w++) begin
      doReset();
      step(ACT, 0, 1, g);
      idle(T_RRD - 1);
      step(ACT, 1, 2, g);
      idle(T_RCD - 1);
      step(WR, 0, 0, g);
      idle(w - 1);
      step(RD, 1, 0, g);
      chk($sformatf("R8 rd after wr gap%0d", w), g, w >= BURST + T_WTR);
    end

    // R9: column spacing over all orders
    for (int c1 = 0; c1 < 2; c1++)
      for (int c2 = 0; c2 < 2; c2++)
        for (int gap = 1; gap <= 5; gap++) begin
          doReset();
          step(ACT, 0, 1, g);
          idle(T_RCD - 1);
          step(c1 ? WR : RD, 0, 0, g);
          idle(gap - 1);
          step(c2 ? WR : RD, 0, 0, g);
          chk($sformatf("R9 first%0d second%0d gap%0d", c1, c2, gap), g,
              (c1 == 1 && c2 == 0) ? (gap >= BURST + T_WTR) : (gap >= BURST));
        end

    // R10: precharge-all waits for the youngest bank
    for (int gap = T_RAS - 3; gap <= T_RAS + 2; gap++) begin
      doReset();
      step(ACT, 0, 1, g);
      idle(T_RRD - 1);
      step(ACT, 2, 2, g);
      idle(gap - 1);
      step(PREA, 0, 0, g);
      chk($sformatf("R10 prea gap%0d", gap), g, gap >= T_RAS);
      idle(1);
      chk($sformatf("R10 open after prea gap%0d", gap), bankOpen, gap >= T_RAS ? 0 : 5);
    end
    for (int w = 1; w <= BURST + T_WR + 1; w++) begin
      doReset();
      step(ACT, 1, 1, g);
      idle(T_RAS);
      step(WR, 1, 0, g);
      idle(w - 1);
      step(PREA, 0, 0, g);
      chk($sformatf("R10 R7 prea after wr gap%0d", w), g, w >= BURST + T_WR);
    end

    // R11: mode write and refresh need idle banks and precharge time
    doReset();
    step(MRS, 0, 0, g);
    chk("R11 mrs after reset", g, 1);
    for (int c = 0; c < 2; c++)
      for (int p = 1; p <= T_RP + 2; p++) begin
        doReset();
        step(ACT, 3, 4, g);
        idle(T_RAS - 1);
        step(c ? REF : MRS, 0, 0, g);
        chk($sformatf("R11 cmd%0d with bank open", c), g, 0);
        step(PRE, 3, 0, g);
        idle(p - 1);
        step(c ? REF : MRS, 0, 0, g);
        chk($sformatf("R11 cmd%0d after pre gap%0d", c, p), g, p >= T_RP);
      end

    // R12: recovery after mode write and refresh
    for (int gap = 1; gap <= T_MRD + 2; gap++) begin
      doReset();
      step(MRS, 0, 0, g);
      idle(gap - 1);
      step(ACT, 0, 1, g);
      chk($sformatf("R12 act after mrs gap%0d", gap), g, gap >= T_MRD);
    end
    for (int gap = T_RFC - 2; gap <= T_RFC + 1; gap++) begin
      doReset();
      step(REF, 0, 0, g);
      idle(gap - 1);
      step(REF, 0, 0, g);
      chk($sformatf("R12 ref after ref gap%0d", gap), g, gap >= T_RFC);
    end

    // R13: stalled activate keeps the old row
    doReset();
    step(ACT, 1, 12'h123, g);
    idle(T_RCD);
    step(ACT, 1, 12'h456, g);
    chk("R13 re-act stalled", g, 0);
    idle(1);
    chk("R13 row kept", rowOf(1), 12'h123);
    chk("R13 open kept", bankOpen, 4'b0010);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule